// File: doc/BRIEF.md
# Initial Program Load Handshake Sequencer

This block sits on the processor side of an I/O channel and runs the start-up load handshake with the attached devices. A press of the Load key starts a sequence. The block raises an initiate line, raises a first system-reset pulse, and drives one bit of a two-bit source-select bus; the two-position source switch decides which bit. After the first reset is released, the block waits for the selected device to answer on the returned tag line. It then drops the initiate line, waits a minimum gap, and issues a second system-reset pulse. When the second reset ends, a load-phase flag tells the storage-load logic that it may start.

All minimum widths and gaps are given in nanoseconds and are converted to clock cycles, rounded up, from a clock-frequency parameter. The tag line can arrive skewed against the reset line. For that reason, the tag is only looked at once the first reset has been driven and then released. If no tag arrives within a timeout after the first reset ends, the sequence is abandoned with an error flag.

Top module: `ipl_sequencer`

## Requirements
- R1: A detected press in idle raises `init_ipl` and `sys_reset` together with exactly one `src_sel` bit. Bit 0 is set when `src_alt` was 0 at the press (primary), and bit 1 is set when it was 1 (alternate).
- R2: While `init_ipl` is high, `src_sel` keeps the value latched at the press and does not follow later changes of `src_alt`.
- R3: The first reset stays high for exactly ceil(RST1_NS × CLK_HZ / 1e9) cycles. That is 480 cycles at 100 MHz.
- R4: A returned tag that goes high and low again while the first reset is still asserted is not accepted. `init_ipl` stays high after the reset ends.
- R5: A tag seen high after the first reset has ended drops `init_ipl`. From then on `src_sel` reads 0.
- R6: The second reset rises exactly ceil(GAP_NS × CLK_HZ / 1e9) cycles after `init_ipl` falls (20 cycles at 100 MHz). `init_ipl` stays low during that gap.
- R7: If no tag is seen within TAG_TIMEOUT cycles after the first reset ends, `init_ipl` falls exactly TAG_TIMEOUT cycles after that release and `ipl_error` goes high. No second reset follows, and the error flag stays set until the next accepted press.
- R8: The second reset lasts RST2_CYC cycles. `load_active` rises in the same cycle in which the second reset falls.
- R9: Load key presses made while a sequence is running, including the load phase, start nothing.
- R10: `load_done` ends the load phase: `load_active` falls and the block returns to idle.
- R11: While `rst_n` is low, every output is 0, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_key | input | 1 | Load key, asynchronous level |
| src_alt | input | 1 | Source switch: 0 primary, 1 alternate |
| ipl_tag | input | 1 | Returned tag from the selected device, asynchronous |
| load_done | input | 1 | Ends the storage-load phase |
| init_ipl | output | 1 | Initiate-load line |
| src_sel | output | 2 | Source-select bus, one-hot while `init_ipl` is high |
| sys_reset | output | 1 | System reset line, pulsed twice per sequence |
| load_active | output | 1 | Storage-load phase may run |
| ipl_error | output | 1 | Tag timeout occurred |

## Verification
The hardest case to reach is a skewed tag that shows up during the first reset and vanishes before that reset is released. The stimulus raises the tag as soon as `init_ipl` appears and removes it well before the reset width expires. It then checks that `init_ipl` is still held after the release. The timeout path needs a sequence in which the tag never comes at all. It is followed at once by a good sequence, which shows that the error flag is cleared and that the switch is latched again.

// File: rtl/ipl_sequencer.sv
module ipl_sequencer #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int RST1_NS     = 4800,
  parameter int GAP_NS      = 200,
  parameter int RST2_CYC    = 16,
  parameter int TAG_TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_key,
  input  logic       src_alt,
  input  logic       ipl_tag,
  input  logic       load_done,
  output logic       init_ipl,
  output logic [1:0] src_sel,
  output logic       sys_reset,
  output logic       load_active,
  output logic       ipl_error
);
  localparam longint KHZ    = longint'(CLK_HZ) / 1000;
  localparam int RST1_RAW   = int'((longint'(RST1_NS) * KHZ + 999_999) / 1_000_000);
  localparam int GAP_RAW    = int'((longint'(GAP_NS) * KHZ + 999_999) / 1_000_000);
  localparam int RST1_CYC   = (RST1_RAW < 1) ? 1 : RST1_RAW;
  localparam int GAP_CYC    = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int M1         = (RST1_CYC > GAP_CYC) ? RST1_CYC : GAP_CYC;
  localparam int M2         = (RST2_CYC > TAG_TIMEOUT) ? RST2_CYC : TAG_TIMEOUT;
  localparam int MAXC       = (M1 > M2) ? M1 : M2;
  localparam int CW         = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST1, S_WAIT, S_GAP, S_RST2, S_LOAD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          alt_q;
  logic [2:0]    key_sy;
  logic [1:0]    tag_sy;
  logic          press, tag_s, last;

  assign press = key_sy[1] & ~key_sy[2];
  assign tag_s = tag_sy[1];

  always_comb begin
    last = 1'b0;
    case (st)
      S_RST1:  last = (cnt == CW'(RST1_CYC - 1));
      S_WAIT:  last = (cnt == CW'(TAG_TIMEOUT - 1));
      S_GAP:   last = (cnt == CW'(GAP_CYC - 1));
      S_RST2:  last = (cnt == CW'(RST2_CYC - 1));
      default: last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_sy <= '0;
      tag_sy <= '0;
    end else begin
      key_sy <= {key_sy[1:0], load_key};
      tag_sy <= {tag_sy[0], ipl_tag};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      alt_q     <= 1'b0;
      ipl_error <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (press) begin
          st        <= S_RST1;
          cnt       <= '0;
          alt_q     <= src_alt;
          ipl_error <= 1'b0;
        end
        S_RST1: if (last) begin
          st  <= S_WAIT;
          cnt <= '0;
        end
        S_WAIT: if (tag_s) begin
          st  <= S_GAP;
          cnt <= '0;
        end else if (last) begin
          st        <= S_IDLE;
          ipl_error <= 1'b1;
        end
        S_GAP: if (last) begin
          st  <= S_RST2;
          cnt <= '0;
        end
        S_RST2: if (last) st <= S_LOAD;
        S_LOAD: if (load_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign init_ipl    = (st == S_RST1) || (st == S_WAIT);
  assign sys_reset   = (st == S_RST1) || (st == S_RST2);
  assign load_active = (st == S_LOAD);
  assign src_sel     = init_ipl ? (alt_q ? 2'b10 : 2'b01) : 2'b00;

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ipl) |-> sys_reset && $onehot(src_sel)); // R1
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    init_ipl && $past(init_ipl) |-> $stable(src_sel)); // R2
  AST_RST1_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_reset) && init_ipl |-> $past(cnt) == CW'(RST1_CYC - 1)); // R3
  AST_GAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset) && !init_ipl |-> $past(cnt) == CW'(GAP_CYC - 1)); // R6
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipl_error) |-> !init_ipl && !sys_reset && !load_active); // R7
  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    load_active |-> !sys_reset && !init_ipl && src_sel == 2'b00); // R8
endmodule

// File: tb/sim_ipl_sequencer.sv
module sim_ipl_sequencer;
  localparam int HZ   = 100_000_000;
  localparam int RST1 = 480;
  localparam int GAP  = 20;
  localparam int RST2 = 8;
  localparam int TMO  = 40;
  localparam logic [7:0] NEVER = 8'hFF;

  logic clk = 0, rst_n = 0, load_key = 0, src_alt = 0, ipl_tag = 0, load_done = 0;
  logic init_ipl, sys_reset, load_active, ipl_error;
  logic [1:0] src_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipl_sequencer #(.CLK_HZ(HZ), .RST1_NS(4800), .GAP_NS(200),
                  .RST2_CYC(RST2), .TAG_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .load_key(load_key), .src_alt(src_alt),
    .ipl_tag(ipl_tag), .load_done(load_done), .init_ipl(init_ipl),
    .src_sel(src_sel), .sys_reset(sys_reset), .load_active(load_active),
    .ipl_error(ipl_error));

  // {alt, early tag, tag delay after first reset release}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd0}, {1'b1, 1'b0, 8'd5}, {1'b0, 1'b1, 8'd10},
    {1'b1, 1'b1, 8'd20}, {1'b0, 1'b0, NEVER}, {1'b1, 1'b0, 8'd3}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic alt, input logic early, input logic [7:0] dly);
    int n, w;
    bit sel_ok;
    @(negedge clk);
    src_alt = alt; load_key = 1;
    n = 0;
    while (!init_ipl && n < 20) begin @(negedge clk); n++; end
    load_key = 0;
    chk(init_ipl && sys_reset, "R1 init and reset together", int'(sys_reset), 1);
    chk(src_sel == (alt ? 2'b10 : 2'b01), "R1 source bit", int'(src_sel), alt ? 2 : 1);
    src_alt = ~alt;
    if (early) ipl_tag = 1;
    w = 0; sel_ok = 1;
    while (sys_reset && w < 2000) begin
      @(negedge clk); w++;
      if (early && w == 50) ipl_tag = 0;
      if (sys_reset && src_sel != (alt ? 2'b10 : 2'b01)) sel_ok = 0;
    end
    chk(sel_ok, "R2 select held", int'(sel_ok), 1);
    chk(w == RST1, "R3 first reset width", w, RST1);
    if (early) chk(init_ipl == 1, "R4 early tag ignored", int'(init_ipl), 1);
    n = 0;
    if (dly == NEVER) begin
      while (init_ipl && n < 500) begin @(negedge clk); n++; end
      chk(n == TMO, "R7 timeout length", n, TMO);
      chk(ipl_error == 1, "R7 error flag", int'(ipl_error), 1);
      repeat (GAP + 5) @(negedge clk);
      chk(!sys_reset && !load_active && ipl_error, "R7 no second reset", int'(sys_reset), 0);
    end else begin
      while (init_ipl && n < 500) begin
        if (n == int'(dly)) ipl_tag = 1;
        @(negedge clk); n++;
      end
      chk(n <= int'(dly) + 3 && !ipl_error, "R5 tag accepted", n, int'(dly) + 3);
      chk(src_sel == 2'b00, "R5 bus cleared", int'(src_sel), 0);
      w = 0;
      while (!sys_reset && w < 500) begin @(negedge clk); w++;
        if (init_ipl) sel_ok = 0; end
      chk(w == GAP && sel_ok, "R6 gap", w, GAP);
      w = 0;
      while (sys_reset && w < 500) begin @(negedge clk); w++; end
      chk(w == RST2, "R8 second reset width", w, RST2);
      chk(load_active == 1, "R8 load phase", int'(load_active), 1);
      ipl_tag = 0;
      load_key = 1; repeat (6) @(negedge clk); load_key = 0;
      repeat (4) @(negedge clk);
      chk(load_active && !init_ipl && !sys_reset, "R9 press in load ignored", int'(init_ipl), 0);
      load_done = 1; @(negedge clk); load_done = 0;
      chk(load_active == 0, "R10 load done", int'(load_active), 0);
      repeat (6) @(negedge clk);
      chk(init_ipl == 0, "R10 idle after done", int'(init_ipl), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({init_ipl, src_sel, sys_reset, load_active, ipl_error} == 6'b0, "R11 reset state",
        int'({init_ipl, src_sel, sys_reset, load_active, ipl_error}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(init_ipl == 0, "R9 idle without press", int'(init_ipl), 0);
    foreach (VEC[i]) run_seq(VEC[i][9], VEC[i][8], VEC[i][7:0]);
    chk(ipl_error == 0, "R7 error cleared by new press", int'(ipl_error), 0);
    load_key = 1; repeat (30) @(negedge clk);
    chk(init_ipl && sys_reset, "R1 sequence running", int'(init_ipl), 1);
    rst_n = 0; @(negedge clk);
    chk({init_ipl, src_sel, sys_reset, load_active} == 5'b0, "R11 reset mid sequence",
        int'({init_ipl, src_sel, sys_reset, load_active}), 0);
    load_key = 0; rst_n = 1;
    repeat (5) @(negedge clk);
    chk(init_ipl == 0, "R11 stays idle after reset", int'(init_ipl), 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150_000) begin @(posedge clk); cyc++; end
    if (!done) chk(0, "watchdog", cyc, 150_000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule